// File: doc/BRIEF.md
# CD Serial Audio Frame Receiver

This block takes the serial audio stream that a CD servo or read-channel device sends on four wires: a bit clock, a left/right clock, a data line and an error-flag line. It recovers one 16-bit sample for every half of the left/right clock, together with two error bits that mark the upper and lower byte of that sample. Each recovered word carries a channel tag and is handed to the next stage, normally a FIFO, through a valid/ready pair.

The serial inputs belong to the bit-clock domain. They enter the system clock domain through two-flop synchronisers. The bit clock is then oversampled, so the system clock must run at least eight times faster than the bit clock. Static configuration inputs select the framing: 16, 24 or 32 bit clocks per channel half, the bit order, which channel the low level of the left/right clock means, the order of the two error flags, the sampling edge, and whether an error-flag line exists at all. A left/right transition that comes before a channel half is complete drops the partial sample and sets a sticky framing-error output.

The framer is a state machine with four states:
- `ST_HUNT`: waiting for the first left/right transition after reset.
- `ST_SKIP`: discarding the leading invalid bits of a half.
- `ST_SHIFT`: collecting sample bits.
- `ST_HOLD`: the sample is complete and the framer waits for the next transition.

The transitions are:
- start: any state to `ST_SKIP`, or to `ST_SHIFT` when the span is 16, on a transition.
- lead_done: `ST_SKIP` to `ST_SHIFT` after the last invalid bit.
- sample_done: `ST_SHIFT` to `ST_HOLD` after the sixteenth sample bit.
- early_edge: the start transition taken from `ST_SKIP` or `ST_SHIFT`. It also raises the framing error.

Top module: `cd_frame_rx`

## Requirements
- R1: `cfg_span` selects the bit clocks per channel half: code 0 gives 16, code 1 gives 24, codes 2 and 3 give 32. The first span−16 bits of a half are discarded, and the last 16 bits form the sample.
- R2: With `cfg_lsb_first`=1 the first sample bit received is bit 0 of `out_sample`. With `cfg_lsb_first`=0 it is bit 15.
- R3: `out_chan` is 0 for left and 1 for right. With `cfg_left_low`=1, a low left/right clock means left. With `cfg_left_low`=0, it means right.
- R4: `out_err[1]` flags the upper byte and `out_err[0]` flags the lower byte. Each flag is the OR of `cd_eflag` over one group of 8 sample bits. With `cfg_flag_lower_first`=0 the first group gives the upper flag; with 1 it gives the lower flag. The flag line is ignored during invalid bits.
- R5: With `cfg_no_flag`=1, `out_err` is 00 whatever `cd_eflag` does.
- R6: With `cfg_fall_edge`=0, data, left/right clock and flag are sampled on the rising bit-clock edge. With 1, they are sampled on the falling edge.
- R7: A channel half starts at every left/right transition, and the bit count restarts there. Bits before the first transition after reset produce no word and no error.
- R8: A transition that arrives before a half has delivered its full span sets `frm_err`. The partial sample is dropped, `frm_err` stays set until reset, and the following half is received normally.
- R9: `out_valid` with its word stays asserted and unchanged until `out_ready` is high. A word that completes while the previous one is still unaccepted is discarded.
- R10: After reset, `out_valid` and `frm_err` are 0.
- R11: Bits received after a half is complete and before the next transition are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd_bck | input | 1 | Serial bit clock |
| cd_lrck | input | 1 | Left/right channel clock |
| cd_data | input | 1 | Serial sample data |
| cd_eflag | input | 1 | Serial error-flag line |
| cfg_span | input | 2 | Bit clocks per half: 0=16, 1=24, 2/3=32 |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_left_low | input | 1 | 1: low left/right clock means left |
| cfg_flag_lower_first | input | 1 | 1: first flag group marks the lower byte |
| cfg_fall_edge | input | 1 | 1: sample on falling bit-clock edge |
| cfg_no_flag | input | 1 | 1: no flag line, report zero flags |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_chan | output | 1 | 0 left, 1 right |
| out_sample | output | 16 | Recovered sample |
| out_err | output | 2 | [1] upper byte flag, [0] lower byte flag |
| frm_err | output | 1 | Sticky framing error |

## Verification
The assertions check four things on every cycle:
- A held word stays stable under backpressure.
- The framing error never clears once set.
- The flags stay zero when the flag line is disabled.
- A new word appears only on the cycle after a detected bit-clock edge.

Only the bench's scenarios can show the bit-level behaviours, because they need a reference built from whole frames. These are the discarding of leading bits for each span, both bit orders, the channel polarity, the flag grouping and order, the sampling edge, the hunt phase before the first transition, a truncated half, and the word dropped while the output is stalled.

// File: rtl/cdrx_pkg.sv
package cdrx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/cdrx_sync.sv
module cdrx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                if (s == 0) chain[s] <= din;
                else        chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cdrx_edge.sv
module cdrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_s,
    input  logic fall_sel,
    output logic bit_edge
);
    logic bck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bck_prev <= 1'b0;
        else        bck_prev <= bck_s;
    end

    // Rising or falling transition of the synchronised bit clock
    assign bit_edge = fall_sel ? (bck_prev & ~bck_s) : (~bck_prev & bck_s);
endmodule

// File: rtl/cdrx_framer.sv
module cdrx_framer
    import cdrx_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int EXTRA_STEP = 8,
    parameter int CNT_W      = $clog2(SAMPLE_W + 2*EXTRA_STEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_edge,
    input  logic             lrck_s,
    input  logic [1:0]       span_code,
    output logic             take,
    output logic [CNT_W-1:0] smp_idx,
    output logic             half_level,
    output logic             frm_err_pulse
);
    localparam int MAX_SPAN = SAMPLE_W + 2*EXTRA_STEP;
    localparam logic [CNT_W-1:0] LEAD_MID  = CNT_W'(EXTRA_STEP);
    localparam logic [CNT_W-1:0] LEAD_LONG = CNT_W'(2*EXTRA_STEP);
    localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(SAMPLE_W-1);
    localparam logic [CNT_W-1:0] POS_MAX   = CNT_W'(MAX_SPAN);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] pos_q;
    logic             primed_q, lrck_prev_q, level_q;
    logic [CNT_W-1:0] lead, idx;
    logic             toggle, in_half;

    always_comb begin
        unique case (span_code)
            2'd0:    lead = '0;
            2'd1:    lead = LEAD_MID;
            default: lead = LEAD_LONG;
        endcase
    end

    assign toggle  = bit_edge && primed_q && (lrck_s != lrck_prev_q);
    assign idx     = toggle ? '0 : pos_q;
    assign in_half = (state_q == ST_SKIP) || (state_q == ST_SHIFT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (toggle) begin
            state_d = (lead == '0) ? ST_SHIFT : ST_SKIP;
        end else if (bit_edge) begin
            unique case (state_q)
                ST_HUNT:  state_d = ST_HUNT;
                ST_SKIP:  if (idx == lead - 1'b1) state_d = ST_SHIFT;
                ST_SHIFT: if (idx == lead + SMP_LAST) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
            endcase
        end
    end

    // State and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_HUNT;
            pos_q       <= '0;
            primed_q    <= 1'b0;
            lrck_prev_q <= 1'b0;
            level_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bit_edge) begin
                primed_q    <= 1'b1;
                lrck_prev_q <= lrck_s;
                if (toggle) begin
                    pos_q   <= CNT_W'(1);
                    level_q <= lrck_s;
                end else if (pos_q != POS_MAX) begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        take          = 1'b0;
        frm_err_pulse = toggle && in_half;
        half_level    = toggle ? lrck_s : level_q;
        smp_idx       = idx - lead;
        if (toggle) begin
            take = (lead == '0);
        end else if (bit_edge) begin
            unique case (state_q)
                ST_SHIFT:                   take = 1'b1;
                ST_HUNT, ST_SKIP, ST_HOLD:  take = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cdrx_assembler.sv
module cdrx_assembler #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [CNT_W-1:0]    smp_idx,
    input  logic                din,
    input  logic                flag_in,
    input  logic                half_level,
    input  logic                lsb_first,
    input  logic                left_low,
    input  logic                lower_first,
    input  logic                no_flag,
    output logic                done,
    output logic                w_chan,
    output logic [SAMPLE_W-1:0] w_sample,
    output logic [1:0]          w_err
);
    localparam logic [CNT_W-1:0] HALF_K   = CNT_W'(SAMPLE_W/2);
    localparam logic [CNT_W-1:0] LAST_K   = CNT_W'(SAMPLE_W-1);

    logic [SAMPLE_W-1:0] shift_q, shift_d;
    logic                grp_a_q, grp_b_q, grp_a_d, grp_b_d;

    always_comb begin
        shift_d = shift_q;
        grp_a_d = grp_a_q;
        grp_b_d = grp_b_q;
        if (take) begin
            shift_d = lsb_first ? {din, shift_q[SAMPLE_W-1:1]}
                                : {shift_q[SAMPLE_W-2:0], din};
            if (smp_idx == '0) begin
                grp_a_d = flag_in;
                grp_b_d = 1'b0;
            end else if (smp_idx < HALF_K) begin
                grp_a_d = grp_a_q | flag_in;
            end else begin
                grp_b_d = grp_b_q | flag_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            grp_a_q <= 1'b0;
            grp_b_q <= 1'b0;
        end else begin
            shift_q <= shift_d;
            grp_a_q <= grp_a_d;
            grp_b_q <= grp_b_d;
        end
    end

    assign done     = take && (smp_idx == LAST_K);
    assign w_sample = shift_d;
    assign w_chan   = half_level ^ ~left_low;
    assign w_err    = no_flag     ? 2'b00 :
                      lower_first ? {grp_b_d, grp_a_d} : {grp_a_d, grp_b_d};
endmodule

// File: rtl/cd_frame_rx.sv
module cd_frame_rx #(
    parameter int SAMPLE_W    = 16,
    parameter int EXTRA_STEP  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cd_bck,
    input  logic                cd_lrck,
    input  logic                cd_data,
    input  logic                cd_eflag,
    input  logic [1:0]          cfg_span,
    input  logic                cfg_lsb_first,
    input  logic                cfg_left_low,
    input  logic                cfg_flag_lower_first,
    input  logic                cfg_fall_edge,
    input  logic                cfg_no_flag,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_chan,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [1:0]          out_err,
    output logic                frm_err
);
    localparam int CNT_W = $clog2(SAMPLE_W + 2*EXTRA_STEP + 1);

    logic [3:0]          pins_s;
    logic                bit_edge, take, half_level, frm_err_pulse, done;
    logic [CNT_W-1:0]    smp_idx;
    logic                w_chan;
    logic [SAMPLE_W-1:0] w_sample;
    logic [1:0]          w_err;

    cdrx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cd_bck, cd_lrck, cd_data, cd_eflag}),
        .dout (pins_s)
    );

    cdrx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bck_s   (pins_s[3]),
        .fall_sel(cfg_fall_edge),
        .bit_edge(bit_edge)
    );

    cdrx_framer #(.SAMPLE_W(SAMPLE_W), .EXTRA_STEP(EXTRA_STEP), .CNT_W(CNT_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_edge     (bit_edge),
        .lrck_s       (pins_s[2]),
        .span_code    (cfg_span),
        .take         (take),
        .smp_idx      (smp_idx),
        .half_level   (half_level),
        .frm_err_pulse(frm_err_pulse)
    );

    cdrx_assembler #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .smp_idx    (smp_idx),
        .din        (pins_s[1]),
        .flag_in    (pins_s[0]),
        .half_level (half_level),
        .lsb_first  (cfg_lsb_first),
        .left_low   (cfg_left_low),
        .lower_first(cfg_flag_lower_first),
        .no_flag    (cfg_no_flag),
        .done       (done),
        .w_chan     (w_chan),
        .w_sample   (w_sample),
        .w_err      (w_err)
    );

    // Single-entry output register toward the FIFO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_chan   <= 1'b0;
            out_sample <= '0;
            out_err    <= 2'b00;
            frm_err    <= 1'b0;
        end else begin
            if (frm_err_pulse) frm_err <= 1'b1;
            if (done && (!out_valid || out_ready)) begin
                out_valid  <= 1'b1;
                out_chan   <= w_chan;
                out_sample <= w_sample;
                out_err    <= w_err;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cdrx_checker.sv
module cdrx_checker #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                out_valid,
    input logic                out_ready,
    input logic                out_chan,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic [1:0]          out_err,
    input logic                frm_err,
    input logic                cfg_no_flag,
    input logic                bit_edge
);
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable({out_chan, out_err, out_sample}));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> frm_err);

    // R5
    no_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_no_flag |-> out_err == 2'b00);

    // R7
    load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(bit_edge));
endmodule

bind cd_frame_rx cdrx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_chan   (out_chan),
    .out_sample (out_sample),
    .out_err    (out_err),
    .frm_err    (frm_err),
    .cfg_no_flag(cfg_no_flag),
    .bit_edge   (bit_edge)
);

// File: tb/cd_frame_rx_tb.sv
module cd_frame_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cd_bck = 1'b0, cd_lrck = 1'b0, cd_data = 1'b0, cd_eflag = 1'b0;
    logic [1:0]  cfg_span = 2'd0;
    logic        cfg_lsb_first = 1'b0, cfg_left_low = 1'b1, cfg_flag_lower_first = 1'b0;
    logic        cfg_fall_edge = 1'b0, cfg_no_flag = 1'b0;
    logic        out_valid, out_ready = 1'b1, out_chan, frm_err;
    logic [15:0] out_sample;
    logic [1:0]  out_err;

    int total = 0;
    int bad   = 0;
    logic [18:0] got_q[$];
    logic [18:0] exp_q[$];

    always #5 clk = ~clk;

    cd_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cd_bck(cd_bck), .cd_lrck(cd_lrck),
        .cd_data(cd_data), .cd_eflag(cd_eflag), .cfg_span(cfg_span),
        .cfg_lsb_first(cfg_lsb_first), .cfg_left_low(cfg_left_low),
        .cfg_flag_lower_first(cfg_flag_lower_first), .cfg_fall_edge(cfg_fall_edge),
        .cfg_no_flag(cfg_no_flag), .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_sample(out_sample), .out_err(out_err), .frm_err(frm_err)
    );

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) got_q.push_back({out_chan, out_err, out_sample});

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int span_of(input logic [1:0] code);
        return (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
    endfunction

    // Reference word: {chan, err_upper, err_lower, sample}
    function automatic logic [18:0] ref_word(input logic lv, input logic [15:0] smp,
                                             input logic fu, input logic fl);
        logic ch;
        logic [1:0] e;
        ch = cfg_left_low ? lv : ~lv;
        e  = cfg_no_flag ? 2'b00 : {fu, fl};
        return {ch, e, smp};
    endfunction

    task automatic drive_bit(input logic lv, input logic d, input logic f);
        cd_bck = cfg_fall_edge; cd_lrck = lv; cd_data = d; cd_eflag = f;
        tick(4);
        cd_bck = ~cfg_fall_edge;
        tick(4);
    endtask

    task automatic send_half(input logic lv, input int nbits, input bit expect_it);
        logic [15:0] smp;
        logic fu, fl, fa, fb, d, f;
        int lead, pa, pb, k;
        smp  = 16'($urandom);
        fu   = 1'($urandom);
        fl   = 1'($urandom);
        fa   = cfg_flag_lower_first ? fl : fu;
        fb   = cfg_flag_lower_first ? fu : fl;
        pa   = $urandom % 8;
        pb   = 8 + $urandom % 8;
        lead = span_of(cfg_span) - 16;
        for (int i = 0; i < nbits; i++) begin
            k = i - lead;
            if (k >= 0 && k < 16) begin
                d = cfg_lsb_first ? smp[k] : smp[15-k];
                if (cfg_no_flag) f = 1'($urandom);
                else             f = (k == pa) ? fa : (k == pb) ? fb : 1'b0;
            end else begin
                d = 1'($urandom);
                f = 1'($urandom);
            end
            drive_bit(lv, d, f);
        end
        if (expect_it) exp_q.push_back(ref_word(lv, smp, fu, fl));
    endtask

    task automatic start_cfg(input logic [1:0] sp, input logic lsb, input logic ll,
                             input logic lf, input logic fe, input logic nf, output logic lv);
        rst_n = 1'b0;
        cfg_span = sp; cfg_lsb_first = lsb; cfg_left_low = ll;
        cfg_flag_lower_first = lf; cfg_fall_edge = fe; cfg_no_flag = nf;
        cd_bck = fe; out_ready = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        got_q.delete();
        exp_q.delete();
        check(!out_valid && !frm_err, "R10", {out_valid, frm_err}, 0);
        lv = 1'($urandom);
        // Hunt phase: bits before the first transition give nothing
        drive_bit(~lv, 1'($urandom), 1'($urandom));
        drive_bit(~lv, 1'($urandom), 1'($urandom));
        drive_bit(~lv, 1'($urandom), 1'($urandom));
    endtask

    task automatic finish_cfg(input string tag, input logic err_exp);
        int n;
        tick(20);
        check(got_q.size() == exp_q.size(), "R7", got_q.size(), exp_q.size());
        check(frm_err == err_exp, "R8", frm_err, err_exp);
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    endtask

    task automatic run_cfg(input string tag, input logic [1:0] sp, input logic lsb,
                           input logic ll, input logic lf, input logic fe, input logic nf,
                           input int halves, input int max_extra);
        logic lv;
        start_cfg(sp, lsb, ll, lf, fe, nf, lv);
        for (int h = 0; h < halves; h++) begin
            send_half(lv, span_of(sp) + ((max_extra > 0) ? ($urandom % (max_extra + 1)) : 0), 1'b1);
            lv = ~lv;
        end
        finish_cfg(tag, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(2);
        run_cfg("R1", 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6, 0);
        run_cfg("R1", 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6, 0);
        run_cfg("R2", 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6, 0);
        run_cfg("R3", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6, 0);
        run_cfg("R4", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8, 0);
        run_cfg("R5", 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6, 0);
        run_cfg("R6", 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6, 0);
        for (int r = 0; r < 8; r++)
            run_cfg("R11", 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 6, 3);

        // R8: truncated half raises the sticky error and is dropped
        begin
            logic lv;
            start_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, lv);
            send_half(lv, 24, 1'b1);
            send_half(~lv, 10, 1'b0);
            check(frm_err == 1'b0, "R8", frm_err, 0);
            send_half(lv, 24, 1'b1);
            send_half(~lv, 24, 1'b1);
            finish_cfg("R8", 1'b1);
        end

        // R9: backpressure holds the word, the next completed word is discarded
        begin
            logic lv;
            logic [18:0] held;
            start_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, lv);
            out_ready = 1'b0;
            send_half(lv, 16, 1'b1);
            send_half(~lv, 16, 1'b0);
            tick(10);
            held = exp_q[0];
            check(out_valid == 1'b1, "R9", out_valid, 1);
            check({out_chan, out_err, out_sample} == held, "R9", {out_chan, out_err, out_sample}, held);
            tick(25);
            check({out_chan, out_err, out_sample} == held, "R9", {out_chan, out_err, out_sample}, held);
            out_ready = 1'b1;
            send_half(lv, 16, 1'b1);
            send_half(~lv, 16, 1'b1);
            finish_cfg("R9", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule